// File: doc/BRIEF.md
# Multiplexed general-purpose I/O port

This block is one eight-pin digital I/O port. Software reaches a small bank of per-pin control registers through a plain register read/write bus. Each pin has bits for drive direction, output level, pull-resistor enable, a two-bit function code, interrupt enable, interrupt edge choice and an interrupt flag. The function code sends either the port's own output register or one of three peripheral outputs to each pad. Each pad input passes through a two-stage synchronizer. Its synchronized value goes to software as a read-only register and to the peripherals as a parallel bus.

An edge detector on every pin raises that pin's flag on the chosen transition, but only while the pin is in plain I/O mode (function code 0). The flags that software has enabled are ORed into a single port interrupt request.

The bus is a control path with no data stream, so it has no valid/ready handshake. A write is taken on any clock edge where `bus_we` is high. Read data follows `bus_addr` combinationally, and the block never stalls the bus.

Top module: `gpio_mux_port`

## Requirements
- R1: Reset clears output, direction, pull-enable, both function-select, interrupt-enable, edge-select and flag registers to 0, and `irq` is low.
- R2: `pad_oe` bit n equals direction bit n (register 2), where 1 means output and 0 means input.
- R3: The function code of pin n is {sel_hi[n] (register 5), sel_lo[n] (register 4)}. Code 0 drives `pad_out[n]` from the output register (register 1), and codes 1, 2 and 3 drive it from `periph_a_out[n]`, `periph_b_out[n]` and `periph_c_out[n]`.
- R4: A pin whose pull-enable bit (register 3) is 1 and whose direction bit is 0 raises `pull_up` if its output-register bit is 1, or `pull_dn` if that bit is 0. Otherwise both stay low.
- R5: A change on `pad_in` appears on `pin_sync` and in the input register (register 0) after the second rising clock edge. Writes to register 0 are ignored.
- R6: With edge-select bit (register 7) at 0, a low-to-high synchronized transition sets the pin's flag (register 8). With it at 1, a high-to-low transition sets the flag, and the other direction leaves the flag alone.
- R7: A pin whose function code is not 0 never has its flag set by a pad edge.
- R8: `irq` is high exactly when some pin has both its flag and its interrupt-enable bit (register 6) set.
- R9: A write to register 8 loads the written value into the flags, so writing 0 clears them. A hardware edge in the same cycle as the write still sets its flag.
- R10: Changing an edge-select bit while the pad is steady does not set that pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output levels after function selection |
| pad_oe | output | 8 | Pad output enables |
| pull_up | output | 8 | Pull-up enable per pin |
| pull_dn | output | 8 | Pull-down enable per pin |
| periph_a_out | input | 8 | Peripheral output for function code 1 |
| periph_b_out | input | 8 | Peripheral output for function code 2 |
| periph_c_out | input | 8 | Peripheral output for function code 3 |
| pin_sync | output | 8 | Synchronized pad inputs for peripherals |
| irq | output | 1 | Port interrupt request |

## Verification
The hardest case to produce is a software clear landing in the very cycle that a new pad edge is detected. The edge lags its pad change by two synchronizer stages and one history stage. The stimulus therefore moves the pad and then counts out exactly two clock edges before raising the flag write, so that the write and the detected edge land on the same third edge. A second hard case is flag suppression: the pad edges are driven while the function code is nonzero, and the flag register is read back to show it stayed clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN     = 4'd0,
    REG_OUT    = 4'd1,
    REG_DIR    = 4'd2,
    REG_PULL   = 4'd3,
    REG_SEL_LO = 4'd4,
    REG_SEL_HI = 4'd5,
    REG_IE     = 4'd6,
    REG_EDGE   = 4'd7,
    REG_FLAG   = 4'd8
  } gpio_reg_e;

  typedef enum logic [1:0] {
    FN_GPIO  = 2'd0,
    FN_PERIA = 2'd1,
    FN_PERIB = 2'd2,
    FN_PERIC = 2'd3
  } gpio_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] sel_lo,
  input  logic [W-1:0] sel_hi,
  input  logic [W-1:0] per_a,
  input  logic [W-1:0] per_b,
  input  logic [W-1:0] per_c,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    gpio_fn_e fn;
    assign fn = gpio_fn_e'({sel_hi[n], sel_lo[n]});
    always_comb begin
      unique case (fn)
        FN_GPIO:  pad_out[n] = out_q[n];
        FN_PERIA: pad_out[n] = per_a[n];
        FN_PERIB: pad_out[n] = per_b[n];
        default:  pad_out[n] = per_c[n];
      endcase
    end
    assign pad_oe[n] = dir_q[n];
  end
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] gpio_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] hit
);
  logic [W-1:0] hist_q;
  logic [W-1:0] rise, fall;

  assign rise = level & ~hist_q;
  assign fall = ~level & hist_q;
  assign hit  = ((rise & ~fall_sel) | (fall & fall_sel)) & gpio_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      flag_q <= '0;
    end else begin
      hist_q <= level;
      flag_q <= (wr_en ? wr_data : flag_q) | hit;
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_up,
  output logic [NPINS-1:0]  pull_dn,
  input  logic [NPINS-1:0]  periph_a_out,
  input  logic [NPINS-1:0]  periph_b_out,
  input  logic [NPINS-1:0]  periph_c_out,
  output logic [NPINS-1:0]  pin_sync,
  output logic              irq
);
  logic [NPINS-1:0] out_q, dir_q, pull_q, sel_lo_q, sel_hi_q, ie_q, edge_q;
  logic [NPINS-1:0] flag_q, hit, pull_on;
  logic             flag_wr;

  // Control registers; the input register has no storage here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      pull_q   <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      ie_q     <= '0;
      edge_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        REG_OUT:    out_q    <= bus_wdata;
        REG_DIR:    dir_q    <= bus_wdata;
        REG_PULL:   pull_q   <= bus_wdata;
        REG_SEL_LO: sel_lo_q <= bus_wdata;
        REG_SEL_HI: sel_hi_q <= bus_wdata;
        REG_IE:     ie_q     <= bus_wdata;
        REG_EDGE:   edge_q   <= bus_wdata;
        default:    ;
      endcase
    end
  end

  assign flag_wr = bus_we && (bus_addr == REG_FLAG);

  always_comb begin
    case (bus_addr)
      REG_IN:     bus_rdata = pin_sync;
      REG_OUT:    bus_rdata = out_q;
      REG_DIR:    bus_rdata = dir_q;
      REG_PULL:   bus_rdata = pull_q;
      REG_SEL_LO: bus_rdata = sel_lo_q;
      REG_SEL_HI: bus_rdata = sel_hi_q;
      REG_IE:     bus_rdata = ie_q;
      REG_EDGE:   bus_rdata = edge_q;
      REG_FLAG:   bus_rdata = flag_q;
      default:    bus_rdata = '0;
    endcase
  end

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_pin_mux #(.W(NPINS)) u_mux (
    .out_q   (out_q),
    .dir_q   (dir_q),
    .sel_lo  (sel_lo_q),
    .sel_hi  (sel_hi_q),
    .per_a   (periph_a_out),
    .per_b   (periph_b_out),
    .per_c   (periph_c_out),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  gpio_edge_flags #(.W(NPINS)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (pin_sync),
    .fall_sel  (edge_q),
    .gpio_mode (~(sel_lo_q | sel_hi_q)),
    .wr_en     (flag_wr),
    .wr_data   (bus_wdata),
    .flag_q    (flag_q),
    .hit       (hit)
  );

  assign pull_on = pull_q & ~dir_q;
  assign pull_up = pull_on & out_q;
  assign pull_dn = pull_on & ~out_q;
  assign irq     = |(flag_q & ie_q);
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pull_up,
  input logic [NPINS-1:0]  pull_dn,
  input logic              irq,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  sel_lo_q,
  input logic [NPINS-1:0]  sel_hi_q,
  input logic [NPINS-1:0]  ie_q,
  input logic [NPINS-1:0]  flag_q
);
  logic flag_write;
  assign flag_write = bus_we && (bus_addr == REG_FLAG);

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe == dir_q);

  p_gpio_pins_drive_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ out_q) & ~(sel_lo_q | sel_hi_q)) == '0);

  p_pull_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up & pull_dn) == '0) && (((pull_up | pull_dn) & pad_oe) == '0));

  p_no_flag_in_periph_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_write) |->
      ((flag_q & ~$past(flag_q) & $past(sel_lo_q | sel_hi_q)) == '0));

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_q & ie_q) != '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pull_up  (pull_up),
  .pull_dn  (pull_dn),
  .irq      (irq),
  .out_q    (out_q),
  .dir_q    (dir_q),
  .sel_lo_q (sel_lo_q),
  .sel_hi_q (sel_hi_q),
  .ie_q     (ie_q),
  .flag_q   (flag_q)
);

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pull_up, pull_dn, pin_sync;
  logic [7:0] periph_a_out = 8'hA5;
  logic [7:0] periph_b_out = 8'h3C;
  logic [7:0] periph_c_out = 8'h96;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_IN = 4'd0, A_OUT = 4'd1, A_DIR = 4'd2, A_PULL = 4'd3,
                         A_SLO = 4'd4, A_SHI = 4'd5, A_IE = 4'd6, A_EDGE = 4'd7,
                         A_FLAG = 4'd8;

  // {function code, output register, expected pad_out} for R3
  localparam logic [17:0] VEC [5] = '{
    {2'd0, 8'h55, 8'h55},
    {2'd0, 8'hAA, 8'hAA},
    {2'd1, 8'h00, 8'hA5},
    {2'd2, 8'hFF, 8'h3C},
    {2'd3, 8'h00, 8'h96}
  };

  always #10 clk = ~clk;

  gpio_mux_port dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
    .periph_a_out(periph_a_out), .periph_b_out(periph_b_out),
    .periph_c_out(periph_c_out), .pin_sync(pin_sync), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_DIR, v);  check("R1 dir", v, 8'h00);
    rd(A_OUT, v);  check("R1 out", v, 8'h00);
    rd(A_SLO, v);  check("R1 sel_lo", v, 8'h00);
    rd(A_SHI, v);  check("R1 sel_hi", v, 8'h00);
    rd(A_FLAG, v); check("R1 flag", v, 8'h00);
    rd(A_IE, v);   check("R1 ie", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 direction
    wr(A_DIR, 8'hC3);
    check("R2 pad_oe", pad_oe, 8'hC3);

    // R3 vector table
    for (int i = 0; i < 5; i++) begin
      wr(A_OUT, VEC[i][15:8]);
      wr(A_SLO, {8{VEC[i][16]}});
      wr(A_SHI, {8{VEC[i][17]}});
      check("R3 pad_out", pad_out, VEC[i][7:0]);
    end
    wr(A_SLO, 8'h0F); wr(A_SHI, 8'h00); wr(A_OUT, 8'hF0);
    check("R3 mixed codes", pad_out, 8'hF5);
    wr(A_SLO, 8'h00);

    // R4 pull resistor
    wr(A_DIR, 8'h0F); wr(A_PULL, 8'hFF); wr(A_OUT, 8'h3C);
    check("R4 pull_up", pull_up, 8'h30);
    check("R4 pull_dn", pull_dn, 8'hC0);
    wr(A_DIR, 8'h00); wr(A_PULL, 8'h00);

    // R5 sync latency, R6 rising edge
    pad_in = 8'h5A;
    step(1);
    rd(A_IN, v);   check("R5 in after one edge", v, 8'h00);
    step(1);
    rd(A_IN, v);   check("R5 in after two edges", v, 8'h5A);
    check("R5 pin_sync", pin_sync, 8'h5A);
    rd(A_FLAG, v); check("R6 flag not yet", v, 8'h00);
    step(1);
    rd(A_FLAG, v); check("R6 rising flags", v, 8'h5A);
    wr(A_IN, 8'hFF);
    rd(A_IN, v);   check("R5 input ignores write", v, 8'h5A);

    // R8 irq
    wr(A_IE, 8'h02);
    check("R8 irq enabled flag", {7'd0, irq}, 8'h01);
    wr(A_IE, 8'h04);
    check("R8 irq unflagged enable", {7'd0, irq}, 8'h00);

    // R9 clear by writing 0
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, v); check("R9 clear", v, 8'h00);

    // R6 falling edge
    wr(A_EDGE, 8'hFF);
    pad_in = 8'h00;
    step(3);
    rd(A_FLAG, v); check("R6 falling flags", v, 8'h5A);
    wr(A_FLAG, 8'h00);
    pad_in = 8'hFF;
    step(3);
    rd(A_FLAG, v); check("R6 wrong edge ignored", v, 8'h00);

    // R10 edge-select change with steady pad
    wr(A_EDGE, 8'h00);
    step(2);
    rd(A_FLAG, v); check("R10 select change no flag", v, 8'h00);

    // R7 peripheral pins suppressed (codes 1 and 2)
    pad_in = 8'h00;
    step(3);
    wr(A_SLO, 8'hF0);
    pad_in = 8'hFF;
    step(3);
    rd(A_FLAG, v); check("R7 code1 suppressed", v, 8'h0F);
    wr(A_SLO, 8'h00); wr(A_FLAG, 8'h00);
    wr(A_SHI, 8'h3C);
    pad_in = 8'h00;
    step(3);
    pad_in = 8'hFF;
    step(3);
    rd(A_FLAG, v); check("R7 code2 suppressed", v, 8'hC3);
    wr(A_SHI, 8'h00); wr(A_FLAG, 8'h00);

    // R9 software write and simultaneous edge
    wr(A_FLAG, 8'h03);
    rd(A_FLAG, v); check("R9 write loads", v, 8'h03);
    pad_in = 8'hFE;
    step(3);
    pad_in = 8'hFF;
    step(2);
    bus_we = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h00;
    @(negedge clk);
    bus_we = 1'b0;
    rd(A_FLAG, v); check("R9 set wins over clear", v, 8'h01);
    wr(A_IE, 8'h01);
    check("R8 irq from edge flag", {7'd0, irq}, 8'h01);

    finish_run();
  end
endmodule